// File: doc/BRIEF.md
# Dual-Controller Failover Kill Arbiter

Each of two partner storage controllers carries one copy of this block. It watches the keep-alive strobe that arrives from the partner, and it decides when the partner must be forced into hardware reset through a backplane kill line. Three causes lead to a kill: the keep-alive stops for longer than a firmware-set number of cycles, the partner reports that it is failing, or local firmware reports that the message link between the two controllers is down. The kill is asserted for a minimum pulse and then held until power-on reset. At the end of the minimum pulse a single-cycle failover-start pulse tells firmware that the partner is now disabled and its devices may be taken over.

When the partner kills this controller first, the incoming kill passes through a synchroniser and raises a local reset request that stays up until power-on reset. Sending a kill permanently shuts off recognition of an incoming kill, so once one side has fired the other can no longer reset it. When both sides decide in the same cycle, the incoming kill takes precedence and the local kill is never sent. A backplane presence input marks single-controller operation; without a partner nothing is killed and the keep-alive timeout is not applied.

Top module: `peer_kill_arbiter`

## Requirements
- R1: After power-on reset, kill_out_o, self_reset_o and failover_start_o are 0, and status_o bits 1, 2 and 3 are 0.
- R2: The keep-alive watchdog is armed by the first strobe on hb_strobe_i while the partner is present; each strobe reloads it with timeout_load_i (0 acts as 1). status_o bit 1 becomes 1 exactly L clock edges after the last strobe edge when no further strobe arrives, L being the reload value, and stays 1 until reset; strobes every L cycles or faster keep it 0; before the first strobe it never expires.
- R3: While peer_present_i is 0, the watchdog neither arms nor expires, and no cause asserts kill_out_o.
- R4: With the partner present, a set timeout bit, peer_failing_i or link_down_i asserts kill_out_o from the next clock edge.
- R5: kill_out_o, once asserted, stays 1 until reset; failover_start_o is 1 for exactly one cycle, starting KILL_PULSE (16) edges after kill_out_o rose, and never otherwise.
- R6: kill_in_i is synchronised through two flops; a level of 1 present at edge a raises self_reset_o after edge a+2, and self_reset_o then stays 1 until reset even if kill_in_i falls.
- R7: After kill_out_o has been asserted, kill_in_i has no effect: self_reset_o stays 0.
- R8: status_o bit 0 is peer_present_i, bit 1 the watchdog timeout, bit 2 kill sent, bit 3 kill received, bit 4 peer_cache_present_i.
- R9: If a kill cause and the synchronised incoming kill reach the arbiter in the same cycle, the incoming kill wins: self_reset_o rises and kill_out_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hb_strobe_i | input | 1 | One-cycle keep-alive strobe received from the partner |
| peer_failing_i | input | 1 | Partner has reported that it is failing |
| link_down_i | input | 1 | Inter-controller message link has failed |
| timeout_load_i | input | CNT_W | Watchdog reload value, cycles |
| peer_present_i | input | 1 | Partner controller present on the backplane |
| peer_cache_present_i | input | 1 | Partner cache module present on the backplane |
| kill_in_i | input | 1 | Asynchronous kill from the partner |
| kill_out_o | output | 1 | Kill (hardware reset) driven to the partner |
| self_reset_o | output | 1 | Local reset request after being killed |
| failover_start_o | output | 1 | One-cycle pulse: partner disabled, failover may begin |
| status_o | output | 5 | Status bits, layout in R8 |

## Verification
The assertions check on every cycle that the kill and the local reset request are sticky, that the failover pulse lasts one cycle and only ever follows an already asserted kill, that a strobe or an absent partner never lets the timeout rise, and that a controller which has sent a kill never raises its own reset request. Exact cycle counts only the bench scenarios can show: the timeout landing exactly L edges after a strobe, the failover pulse position after the 16-cycle minimum, the two-flop latency of the received kill, and the precedence of the incoming kill when both sides decide in the same cycle.

// File: rtl/kill_arb_pkg.sv
package kill_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_FIRING,
        ARB_HELD,
        ARB_KILLED
    } arb_state_e;

    localparam int STAT_W        = 5;
    localparam int STAT_PRESENT  = 0;
    localparam int STAT_EXPIRED  = 1;
    localparam int STAT_SENT     = 2;
    localparam int STAT_RECEIVED = 3;
    localparam int STAT_CACHE    = 4;

endpackage

// File: rtl/kill_sync.sv
module kill_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.chain[STAGES-1];

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_strobe_i,
    input  logic             present_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expired_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             expired;
    } wd_regs_t;

    wd_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (hb_strobe_i) begin
            r_d.cnt = reload_i;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end

        if (!present_i) begin
            r_d.armed = 1'b0;
        end else if (hb_strobe_i) begin
            r_d.armed = 1'b1;
        end

        if (r_q.armed && present_i && !hb_strobe_i && (r_q.cnt <= CNT_W'(1))) begin
            r_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expired_o = r_q.expired;

    // R3: an absent partner never lets the timeout rise
    a_r3_absent_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (!present_i && !expired_o) |=> !expired_o);

    // R2: a strobe in a cycle holds the timeout off at that edge
    a_r2_strobe_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_strobe_i && !expired_o) |=> !expired_o);

    // R2: the timeout is sticky
    a_r2_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> expired_o);

endmodule

// File: rtl/kill_fsm.sv
module kill_fsm
    import kill_arb_pkg::*;
#(
    parameter int KILL_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_req_i,
    input  logic kill_seen_i,
    output logic kill_out_o,
    output logic self_reset_o,
    output logic failover_start_o
);
    localparam int PW = (KILL_PULSE > 1) ? $clog2(KILL_PULSE) : 1;
    localparam logic [PW-1:0] LAST = PW'(KILL_PULSE - 1);

    typedef struct packed {
        arb_state_e    state;
        logic [PW-1:0] cnt;
        logic          fo;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.fo = 1'b0;
        unique case (r_q.state)
            ARB_IDLE: begin
                // R9: a synchronised incoming kill takes precedence
                if (kill_seen_i) begin
                    r_d.state = ARB_KILLED;
                end else if (kill_req_i) begin
                    r_d.state = ARB_FIRING;
                    r_d.cnt   = '0;
                end
            end
            ARB_FIRING: begin
                if (r_q.cnt == LAST) begin
                    r_d.state = ARB_HELD;
                    r_d.fo    = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ARB_HELD:   r_d.state = ARB_HELD;
            ARB_KILLED: r_d.state = ARB_KILLED;
            default:    r_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ARB_IDLE, cnt: '0, fo: 1'b0};
        else        r_q <= r_d;
    end

    assign kill_out_o       = (r_q.state == ARB_FIRING) || (r_q.state == ARB_HELD);
    assign self_reset_o     = (r_q.state == ARB_KILLED);
    assign failover_start_o = r_q.fo;

    // R5: kill is held once asserted
    a_r5_kill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        kill_out_o |=> kill_out_o);

    // R5: failover pulse lasts one cycle
    a_r5_failover_single: assert property (@(posedge clk) disable iff (!rst_n)
        failover_start_o |=> !failover_start_o);

    // R5: failover only after the kill has already been on the line
    a_r5_failover_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
        failover_start_o |-> (kill_out_o && $past(kill_out_o)));

    // R6: local reset request is held
    a_r6_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        self_reset_o |=> self_reset_o);

    // R7: a controller that has fired cannot be reset by its partner
    a_r7_sender_immune: assert property (@(posedge clk) disable iff (!rst_n)
        kill_out_o |=> !self_reset_o);

endmodule

// File: rtl/peer_kill_arbiter.sv
module peer_kill_arbiter
    import kill_arb_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int KILL_PULSE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_strobe_i,
    input  logic              peer_failing_i,
    input  logic              link_down_i,
    input  logic [CNT_W-1:0]  timeout_load_i,
    input  logic              peer_present_i,
    input  logic              peer_cache_present_i,
    input  logic              kill_in_i,
    output logic              kill_out_o,
    output logic              self_reset_o,
    output logic              failover_start_o,
    output logic [STAT_W-1:0] status_o
);
    logic kill_seen;
    logic expired;
    logic kill_req;

    kill_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (kill_in_i),
        .sync_o  (kill_seen)
    );

    hb_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk         (clk),
        .rst_n       (rst_n),
        .hb_strobe_i (hb_strobe_i),
        .present_i   (peer_present_i),
        .reload_i    (timeout_load_i),
        .expired_o   (expired)
    );

    // R3/R4: every kill cause is gated by partner presence
    assign kill_req = peer_present_i && (expired || peer_failing_i || link_down_i);

    kill_fsm #(.KILL_PULSE(KILL_PULSE)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .kill_req_i       (kill_req),
        .kill_seen_i      (kill_seen),
        .kill_out_o       (kill_out_o),
        .self_reset_o     (self_reset_o),
        .failover_start_o (failover_start_o)
    );

    always_comb begin
        status_o                = '0;
        status_o[STAT_PRESENT]  = peer_present_i;
        status_o[STAT_EXPIRED]  = expired;
        status_o[STAT_SENT]     = kill_out_o;
        status_o[STAT_RECEIVED] = self_reset_o;
        status_o[STAT_CACHE]    = peer_cache_present_i;
    end

    // R3: no kill leaves towards an absent partner
    a_r3_absent_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (!peer_present_i && !kill_out_o) |=> !kill_out_o);

    // R8: sent and received never coexist
    a_r8_sent_xor_received: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({status_o[STAT_SENT], status_o[STAT_RECEIVED]}) <= 1);

endmodule

// File: tb/peer_kill_arbiter_bench.sv
module peer_kill_arbiter_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             hb_strobe_i, peer_failing_i, link_down_i;
    logic [CNT_W-1:0] timeout_load_i;
    logic             peer_present_i, peer_cache_present_i, kill_in_i;
    logic             kill_out_o, self_reset_o, failover_start_o;
    logic [4:0]       status_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    peer_kill_arbiter u_peer_kill_arbiter (
        .clk                  (clk),
        .rst_n                (rst_n),
        .hb_strobe_i          (hb_strobe_i),
        .peer_failing_i       (peer_failing_i),
        .link_down_i          (link_down_i),
        .timeout_load_i       (timeout_load_i),
        .peer_present_i       (peer_present_i),
        .peer_cache_present_i (peer_cache_present_i),
        .kill_in_i            (kill_in_i),
        .kill_out_o           (kill_out_o),
        .self_reset_o         (self_reset_o),
        .failover_start_o     (failover_start_o),
        .status_o             (status_o)
    );

    // watchdog vectors: reload, idle gap after strobe, presence, expected timeout, expected kill
    localparam int NV = 9;
    localparam int V_RELOAD [NV] = '{4, 4, 4, 1, 10, 10, 2, 0, 4};
    localparam int V_GAP    [NV] = '{3, 4, 5, 1,  9, 11, 2, 1, 8};
    localparam int V_PRES   [NV] = '{1, 1, 1, 1,  1,  1, 1, 1, 0};
    localparam int V_EXP    [NV] = '{0, 1, 1, 1,  0,  1, 1, 1, 0};
    localparam int V_KILL   [NV] = '{0, 0, 1, 0,  0,  1, 0, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic pres, input logic cache);
        rst_n = 1'b0;
        hb_strobe_i = 1'b0; peer_failing_i = 1'b0; link_down_i = 1'b0;
        kill_in_i = 1'b0; timeout_load_i = '0;
        peer_present_i = pres; peer_cache_present_i = cache;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic strobe();
        hb_strobe_i = 1'b1;
        cyc(1);
        hb_strobe_i = 1'b0;
    endtask

    initial begin
        #900000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1 / R8 reset state and status layout
        do_reset(1'b1, 1'b1);
        chk("R1 kill_out after reset", kill_out_o, 0);
        chk("R1 self_reset after reset", self_reset_o, 0);
        chk("R1 failover after reset", failover_start_o, 0);
        chk("R8 status after reset", status_o, 5'b10001);
        do_reset(1'b0, 1'b0);
        chk("R8 status absent partner", status_o, 5'b00000);

        // R2 / R3 / R4 table
        for (int i = 0; i < NV; i++) begin
            do_reset(V_PRES[i][0], 1'b0);
            timeout_load_i = CNT_W'(V_RELOAD[i]);
            strobe();
            cyc(V_GAP[i]);
            chk("R2 timeout bit", status_o[1], V_EXP[i]);
            chk("R4 kill on timeout", kill_out_o, V_KILL[i]);
        end

        // R2 unarmed before first strobe
        do_reset(1'b1, 1'b0);
        timeout_load_i = 16'd3;
        cyc(50);
        chk("R2 unarmed no timeout", status_o[1], 0);

        // R2 keep-alive every L cycles
        timeout_load_i = 16'd5;
        for (int k = 0; k < 8; k++) begin
            strobe();
            cyc(4);
        end
        chk("R2 keep-alive holds off", status_o[1], 0);
        chk("R2 keep-alive no kill", kill_out_o, 0);

        // R4 / R5 / R7 partner failing
        do_reset(1'b1, 1'b0);
        peer_failing_i = 1'b1;
        cyc(1);
        chk("R4 kill on failing flag", kill_out_o, 1);
        chk("R8 status kill sent", status_o, 5'b00101);
        peer_failing_i = 1'b0;
        cyc(15);
        chk("R5 no early failover", failover_start_o, 0);
        cyc(1);
        chk("R5 failover pulse", failover_start_o, 1);
        cyc(1);
        chk("R5 failover one cycle", failover_start_o, 0);
        chk("R5 kill held", kill_out_o, 1);
        kill_in_i = 1'b1;
        cyc(6);
        chk("R7 incoming kill ignored", self_reset_o, 0);
        chk("R7 kill still out", kill_out_o, 1);

        // R3 absent partner: causes ignored
        do_reset(1'b0, 1'b1);
        link_down_i = 1'b1;
        peer_failing_i = 1'b1;
        cyc(20);
        chk("R3 no kill when absent", kill_out_o, 0);

        // R4 link down
        do_reset(1'b1, 1'b0);
        link_down_i = 1'b1;
        cyc(1);
        chk("R4 kill on link down", kill_out_o, 1);

        // R6 received kill
        do_reset(1'b1, 1'b0);
        kill_in_i = 1'b1;
        cyc(2);
        chk("R6 sync latency", self_reset_o, 0);
        cyc(1);
        chk("R6 reset request", self_reset_o, 1);
        chk("R8 status kill received", status_o, 5'b01001);
        kill_in_i = 1'b0;
        peer_failing_i = 1'b1;
        cyc(5);
        chk("R6 reset held", self_reset_o, 1);
        chk("R6 no kill after killed", kill_out_o, 0);

        // R9 same-cycle decision
        do_reset(1'b1, 1'b0);
        kill_in_i = 1'b1;
        cyc(2);
        peer_failing_i = 1'b1;
        cyc(1);
        chk("R9 incoming wins reset", self_reset_o, 1);
        chk("R9 incoming wins no kill", kill_out_o, 0);
        cyc(20);
        chk("R9 no failover", failover_start_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule